// File: doc/BRIEF.md
# Flash Embedded-Operation Status Emulator

This block produces the status byte that a parallel NOR flash puts on its data pins while an embedded program or erase runs. A device model or an FPGA flash emulator uses it. The command decoder outside this block supplies the current operating mode and a pulse that marks the end of a command sequence. It also supplies the mask of sectors chosen for erase, a flag that says the program target is write-protected, and a flag that says the internal pulse budget has run out. The host side supplies chip-enable, output-enable and the sector address of the read.

A status read starts when chip-enable and output-enable are both low after a cycle in which at least one of them was high. Either strobe can therefore delimit the read. At the start of each status read the block updates two toggle bits and latches a fresh status byte. The first toggle bit (bit 6) flips on every read while an operation is actually running and freezes while an erase is suspended. The second toggle bit (bit 2) flips only on reads that land in a sector chosen for erase, in both the running and the suspended erase. It flips only after a command-end pulse has armed it. A program aimed at a protected sector gives a short window of toggling status of a fixed length in clock cycles. After the window, reads fall back to array data.

When the mode is idle and no protect window is running, the block reports that reads return array data. It then clears its toggle state and status byte to zero.

Top module: `nsemu_status`

## Requirements
- R1: After synchronous reset, `dq` reads 8'h00 and `is_status` reads 0.
- R2: In array mode (`op_mode`=0 idle with no protect window running), a read leaves `is_status` at 0 and `dq` at 8'h00. On entering array mode, both toggle bits and the arming of bit 2 clear.
- R3: In modes 1 (program), 2 (erase) and 4 (erase-suspend-program), each status read inverts `dq[6]`. The first read after array mode gives 1.
- R4: In mode 3 (erase-suspended), a status read leaves `dq[6]` unchanged and gives `dq[7]`=1. In all other status reads `dq[7]`=0.
- R5: In modes 2 and 3, once armed, a read whose `rd_sector` has its bit set in `erase_sel` inverts `dq[2]`. A read in a sector whose bit is clear leaves `dq[2]` unchanged.
- R6: Bit 2 is armed by a `cmd_end` pulse and stays unarmed until one arrives. Before arming, reads in a selected sector leave `dq[2]` unchanged.
- R7: In modes 1 and 4, `dq[2]` never changes.
- R8: `dq[5]` reads 1 on a status read in modes 1, 2 or 4 while `limit_hit` is 1, and reads 0 otherwise. Bits 4, 3, 1 and 0 always read 0.
- R9: Between read starts outside array mode, `dq` and `is_status` hold their values.
- R10: A `cmd_end` pulse with `prog_protected`=1 starts a window of CLK_MHZ*WIN_NS/1000 cycles. During the window, reads are status reads with `dq[6]` toggling. After the window, in mode 0, reads return to array mode.
- R11: A read start is recognised when either `ce_n` or `oe_n` makes the pair both low. Pulsing either strobe with the other held low counts as one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | 0 idle, 1 program, 2 erase, 3 erase-suspended, 4 erase-suspend-program |
| cmd_end | input | 1 | One-cycle pulse at the final write strobe of a command |
| prog_protected | input | 1 | Program target lies in a protected sector (sampled with cmd_end) |
| limit_hit | input | 1 | Internal pulse-count limit exceeded |
| erase_sel | input | NSECT | Per-sector erase-selected mask |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_sector | input | SECT_W | Sector index of the read |
| dq | output | 8 | Status byte latched at the last read start |
| is_status | output | 1 | 1 when dq carries status, 0 when the read is an array read |

## Verification
The hardest behaviour to reach from the ports is the interplay between the two toggle bits across mode changes. Bit 6 must freeze on suspend while bit 2 keeps flipping only in selected sectors, and an unarmed erase must hold bit 2. The stimulus sweeps every sector under several erase masks in both running and suspended erase, then continues into suspend-program. It also re-enters erase without a command-end pulse. The protect window is reached through a command-end pulse in idle mode and checked by reads inside it and after it has run out. The reads alternate between the two strobe styles.

// File: rtl/nsemu_pkg.sv
package nsemu_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE   = 3'd0,
        MODE_PROG   = 3'd1,
        MODE_ERASE  = 3'd2,
        MODE_ESUSP  = 3'd3,
        MODE_ESPROG = 3'd4
    } op_mode_e;

    typedef struct packed {
        logic poll;
        logic tog6;
        logic fail;
        logic rsv4;
        logic rsv3;
        logic tog2;
        logic rsv1;
        logic rsv0;
    } status_t;

    // modes in which an embedded algorithm is actually running
    function automatic logic mode_running(input op_mode_e m);
        return (m == MODE_PROG) || (m == MODE_ERASE) || (m == MODE_ESPROG);
    endfunction

    // modes in which the erase-sector toggle is live
    function automatic logic mode_erase_view(input op_mode_e m);
        return (m == MODE_ERASE) || (m == MODE_ESUSP);
    endfunction

endpackage

// File: rtl/nsemu_rd_detect.sv
module nsemu_rd_detect (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    output logic rd_start
);
    logic act;
    logic act_q;

    assign act = ~ce_n & ~oe_n;

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= act;
    end

    assign rd_start = act & ~act_q;
endmodule

// File: rtl/nsemu_prot_win.sv
module nsemu_prot_win #(
    parameter int WIN_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WIN_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (start)       cnt <= LOAD;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/nsemu_toggle.sv
module nsemu_toggle #(
    parameter int NSECT = 8,
    localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              flip6,
    input  logic              flip2_ok,
    input  logic [NSECT-1:0]  erase_sel,
    input  logic [SECT_W-1:0] rd_sector,
    output logic              tog6,
    output logic              tog2
);
    logic [NSECT-1:0] hit;
    logic             sel_hit;

    for (genvar i = 0; i < NSECT; i++) begin : g_sect
        assign hit[i] = erase_sel[i] && (rd_sector == SECT_W'(i));
    end

    assign sel_hit = |hit;

    always_ff @(posedge clk) begin
        if (clear) begin
            tog6 <= 1'b0;
            tog2 <= 1'b0;
        end else begin
            if (flip6)              tog6 <= ~tog6;
            if (flip2_ok && sel_hit) tog2 <= ~tog2;
        end
    end
endmodule

// File: rtl/nsemu_status.sv
module nsemu_status
    import nsemu_pkg::*;
#(
    parameter int NSECT   = 8,
    parameter int CLK_MHZ = 50,
    parameter int WIN_NS  = 1000,
    localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1,
    localparam int WIN_CYC = (CLK_MHZ * WIN_NS / 1000 > 0) ? CLK_MHZ * WIN_NS / 1000 : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_mode,
    input  logic              cmd_end,
    input  logic              prog_protected,
    input  logic              limit_hit,
    input  logic [NSECT-1:0]  erase_sel,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [SECT_W-1:0] rd_sector,
    output logic [7:0]        dq,
    output logic              is_status
);
    op_mode_e mode;
    logic     rd_start;
    logic     win_active;
    logic     array_mode;
    logic     armed;
    logic     poll_q;
    logic     fail_q;
    logic     stat_q;
    logic     tog6;
    logic     tog2;
    logic     flip6;
    logic     flip2_ok;
    status_t  sbyte;

    assign mode = op_mode_e'(op_mode);

    nsemu_rd_detect u_rd (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .rd_start (rd_start)
    );

    nsemu_prot_win #(.WIN_CYC(WIN_CYC)) u_win (
        .clk    (clk),
        .rst    (rst),
        .start  (cmd_end & prog_protected),
        .active (win_active)
    );

    assign array_mode = (mode == MODE_IDLE) && !win_active;
    assign flip6      = rd_start && !array_mode && (mode_running(mode) || win_active);
    assign flip2_ok   = rd_start && !array_mode && mode_erase_view(mode) && armed;

    nsemu_toggle #(.NSECT(NSECT)) u_tog (
        .clk       (clk),
        .clear     (rst | array_mode),
        .flip6     (flip6),
        .flip2_ok  (flip2_ok),
        .erase_sel (erase_sel),
        .rd_sector (rd_sector),
        .tog6      (tog6),
        .tog2      (tog2)
    );

    always_ff @(posedge clk) begin
        if (rst)             armed <= 1'b0;
        else if (cmd_end)    armed <= 1'b1;
        else if (array_mode) armed <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || array_mode) begin
            poll_q <= 1'b0;
            fail_q <= 1'b0;
            stat_q <= 1'b0;
        end else if (rd_start) begin
            poll_q <= (mode == MODE_ESUSP);
            fail_q <= limit_hit && mode_running(mode);
            stat_q <= 1'b1;
        end
    end

    always_comb begin
        sbyte      = '0;
        sbyte.poll = poll_q;
        sbyte.tog6 = tog6;
        sbyte.fail = fail_q;
        sbyte.tog2 = tog2;
    end

    assign dq        = sbyte;
    assign is_status = stat_q;
endmodule

// File: rtl/nsemu_status_chk.sv
module nsemu_status_chk #(
    parameter int NSECT  = 8,
    parameter int SECT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        op_mode,
    input logic              limit_hit,
    input logic [NSECT-1:0]  erase_sel,
    input logic              ce_n,
    input logic              oe_n,
    input logic [SECT_W-1:0] rd_sector,
    input logic              win_active,
    input logic [7:0]        dq,
    input logic              is_status
);
    logic both_low_q;
    logic rd_go;
    logic arr_c;
    logic run_c;

    always_ff @(posedge clk) begin
        if (rst) both_low_q <= 1'b0;
        else     both_low_q <= (!ce_n && !oe_n);
    end

    assign rd_go = !ce_n && !oe_n && !both_low_q;
    assign arr_c = (op_mode == 3'd0) && !win_active;
    assign run_c = (op_mode == 3'd1) || (op_mode == 3'd2) || (op_mode == 3'd4);

    // R2
    arr_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go && arr_c |=> !is_status && dq == 8'h00);

    // R3
    dq6_flip_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go && !arr_c && run_c |=> dq[6] != $past(dq[6]));

    // R4
    susp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go && op_mode == 3'd3 && !win_active |=> $stable(dq[6]) && dq[7]);

    // R5
    dq2_other_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go && !arr_c && !erase_sel[rd_sector] |=> $stable(dq[2]));

    // R8
    fail_bit_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go && !arr_c && run_c && limit_hit |=> dq[5]);

    // R9
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go && !arr_c |=> $stable(dq) && $stable(is_status));
endmodule

bind nsemu_status nsemu_status_chk #(.NSECT(NSECT), .SECT_W(SECT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_mode    (op_mode),
    .limit_hit  (limit_hit),
    .erase_sel  (erase_sel),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .rd_sector  (rd_sector),
    .win_active (win_active),
    .dq         (dq),
    .is_status  (is_status)
);

// File: tb/nsemu_status_tb.sv
module nsemu_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSECT = 8;
    localparam int WIN   = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_mode = 3'd0;
    logic       cmd_end = 1'b0;
    logic       prog_protected = 1'b0;
    logic       limit_hit = 1'b0;
    logic [7:0] erase_sel = 8'h00;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [2:0] rd_sector = 3'd0;
    logic [7:0] dq;
    logic       is_status;

    int total = 0;
    int bad   = 0;

    // bench model
    logic m6 = 1'b0, m2 = 1'b0, marmed = 1'b0, mwin = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nsemu_status #(.NSECT(NSECT), .CLK_MHZ(50), .WIN_NS(1000)) dut_i (
        .clk(clk), .rst(rst), .op_mode(op_mode), .cmd_end(cmd_end),
        .prog_protected(prog_protected), .limit_hit(limit_hit),
        .erase_sel(erase_sel), .ce_n(ce_n), .oe_n(oe_n),
        .rd_sector(rd_sector), .dq(dq), .is_status(is_status)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic in_array();
        return (op_mode == 3'd0) && !mwin;
    endfunction

    task automatic set_mode(input logic [2:0] m, input logic cmd, input logic prot);
        @(negedge clk);
        op_mode = m;
        cmd_end = cmd;
        prog_protected = prot;
        if (cmd && prot) mwin = 1'b1;
        @(negedge clk);
        cmd_end = 1'b0;
        prog_protected = 1'b0;
        if (cmd) marmed = 1'b1;
        if (in_array()) begin
            m6 = 1'b0; m2 = 1'b0; marmed = 1'b0;
        end
    endtask

    // how: 0 both strobes, 1 chip-enable pulse, 2 output-enable pulse
    task automatic do_read(input int sec, input int how, input string req);
        logic [7:0] edq;
        logic       est;
        logic       run, eview;
        @(negedge clk);
        rd_sector = 3'(sec);
        ce_n = (how == 2) ? 1'b0 : 1'b1;
        oe_n = (how == 1) ? 1'b0 : 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        oe_n = 1'b0;
        run   = (op_mode == 3'd1) || (op_mode == 3'd2) || (op_mode == 3'd4);
        eview = (op_mode == 3'd2) || (op_mode == 3'd3);
        if (in_array()) begin
            edq = 8'h00; est = 1'b0;
        end else begin
            if (run || mwin) m6 = ~m6;
            if (eview && marmed && erase_sel[sec]) m2 = ~m2;
            edq = {op_mode == 3'd3, m6, limit_hit & run, 2'b00, m2, 2'b00};
            est = 1'b1;
        end
        @(negedge clk);
        chk(dq == edq, req, dq, edq);
        chk(is_status == est, req, is_status, est);
        ce_n = 1'b1;
        oe_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [7:0] masks [4] = '{8'hA5, 8'h0F, 8'h00, 8'hFF};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(dq == 8'h00, "R1", dq, 0);
        chk(is_status == 1'b0, "R1", is_status, 0);

        // R2 array read, with strobe variants (R11)
        do_read(2, 0, "R2");
        do_read(5, 1, "R2 R11");

        // R3 R7 program: toggling bit 6, bit 2 frozen
        erase_sel = 8'hFF;
        set_mode(3'd1, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) do_read(k, k % 3, "R3 R7");
        // R8 fail flag
        limit_hit = 1'b1;
        do_read(1, 0, "R8");
        do_read(6, 2, "R8");
        limit_hit = 1'b0;

        // R2 back to idle clears toggles
        set_mode(3'd0, 1'b0, 1'b0);
        do_read(0, 0, "R2");

        // R5 R3 erase sweep over masks and sectors
        set_mode(3'd2, 1'b1, 1'b0);
        for (int mi = 0; mi < 4; mi++) begin
            erase_sel = masks[mi];
            for (int s = 0; s < NSECT; s++) do_read(s, s % 3, "R5 R3");
        end
        limit_hit = 1'b1;
        do_read(3, 0, "R8");
        limit_hit = 1'b0;

        // R4 R5 suspended erase
        set_mode(3'd3, 1'b0, 1'b0);
        for (int mi = 0; mi < 2; mi++) begin
            erase_sel = masks[mi];
            limit_hit = mi[0];
            for (int s = 0; s < NSECT; s++) do_read(s, (s + 1) % 3, "R4 R5");
        end
        limit_hit = 1'b0;

        // R7 suspend-program
        set_mode(3'd4, 1'b0, 1'b0);
        erase_sel = 8'hFF;
        for (int s = 0; s < 4; s++) do_read(s, 0, "R7 R3");

        // R6 erase entered without arming
        set_mode(3'd0, 1'b0, 1'b0);
        set_mode(3'd2, 1'b0, 1'b0);
        for (int s = 0; s < 4; s++) do_read(s, 1, "R6");
        set_mode(3'd2, 1'b1, 1'b0);
        do_read(2, 0, "R6");
        do_read(3, 2, "R6");

        // R10 protected program window
        set_mode(3'd0, 1'b0, 1'b0);
        set_mode(3'd0, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) do_read(k, k, "R10");
        repeat (WIN + 5) @(negedge clk);
        mwin = 1'b0;
        m6 = 1'b0; m2 = 1'b0; marmed = 1'b0;
        do_read(4, 0, "R10");
        do_read(4, 1, "R10 R11");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule